// File: doc/BRIEF.md
# Trap Entry Sequencer

This block steers a processor through trap entry. Trap conditions arrive as one-cycle pulses on a request vector and are held as pending until they are serviced. Each request line carries a two-bit timing class that says at which boundary of the running program it may be taken: when the current instruction can be aborted, at an iteration boundary of a long string operation, or when the current instruction has finished. When a pending request meets its boundary, the sequencer enters the trap state. It freezes the program counter and presents the vector address of that trap, which is a fixed base plus the trap number.

The sequencer then inspects the opcode read from the trap location. Only a status-exchange opcode or a status-push opcode is accepted there. Either one starts the status-word swap. Any other opcode redirects the sequence to the instruction-exception trap number at once, and the sequencer waits for that location's opcode. The sequence ends only when the swap datapath reports that the new status words are fully in place. While the sequence runs, the gate that lets a ready interrupt level be acknowledged is held closed.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, `trap_state`, `pc_hold` and `swap_start` are 0, no request is pending, and `intr_ack_gate` equals `intr_ready`.
- R2: A pulse on `trap_req[i]` makes request i pending until it is taken. Taking another request does not clear it, and it is taken later once its boundary is met.
- R3: Bits `trap_class[2i+1:2i]` give the class of request i. Value 0 is taken only in a cycle with `cur_abortable`=1. Value 1 is taken only with `iter_bound`=1. Values 2 and 3 are taken only with `instr_end`=1. A request pulse becomes eligible from the cycle after the pulse.
- R4: When several pending requests are eligible in the same cycle, the lowest-numbered one is taken.
- R5: In the cycle after a take, `trap_state` and `pc_hold` go to 1. They stay at 1 until the sequence ends, and no new trap is taken while they are 1.
- R6: While `trap_state` is 1, `trap_addr` equals TRAP_BASE plus the current trap number.
- R7: In the opcode-wait phase, a valid opcode equal to OPC_XCHG or OPC_PUSH makes `swap_start` 1 for exactly the next cycle.
- R8: In the opcode-wait phase, any other valid opcode changes the trap number to EXC_NUM in the next cycle. The sequencer gives no `swap_start` and waits for a new opcode.
- R9: `intr_ack_gate` is 0 whenever `trap_state` is 1, and equals `intr_ready` otherwise.
- R10: `swap_done` in the swap phase makes `trap_state` 0 in the next cycle. `swap_done` outside the swap phase has no effect.
- R11: `loc_opcode_vld` outside the opcode-wait phase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | N_TRAPS | Trap condition pulses, one per trap number |
| trap_class | input | 2*N_TRAPS | Timing class of each request line |
| cur_abortable | input | 1 | Current instruction may be aborted this cycle |
| iter_bound | input | 1 | Iteration boundary strobe of a long operation |
| instr_end | input | 1 | Instruction completion strobe |
| loc_opcode | input | OPC_W | Opcode read from the trap location |
| loc_opcode_vld | input | 1 | `loc_opcode` is valid |
| intr_ready | input | 1 | An interrupt level is ready to become active |
| swap_done | input | 1 | Status-word replacement has completed |
| trap_addr | output | ADDR_W | Trap location address |
| pc_hold | output | 1 | Inhibit program counter advance |
| trap_state | output | 1 | Trap sequence in progress |
| intr_ack_gate | output | 1 | Interrupt acknowledge allowed |
| swap_start | output | 1 | One-cycle start pulse for the status swap |

## Verification
If the phase register is wrong, it shows up at the ports within one cycle. The block may drop out of the trap state early, which reopens `intr_ack_gate` during a swap. It may stay stuck, in which case `swap_done` fails to clear `trap_state` in the next cycle. A wrong trap number or a lost pending bit shows up on `trap_addr` in the first cycle of the trap that should have used it. A lost bit may also surface later, as a trap that never arrives after its boundary strobe. A wrong swap pulse is visible the cycle after the legal opcode, either missing or lasting more than one cycle.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SWAP  = 2'd2
    } seq_state_e;

    localparam logic [1:0] CLS_ABORT = 2'd0;
    localparam logic [1:0] CLS_ITER  = 2'd1;
endpackage

// File: rtl/trap_pick.sv
module trap_pick #(
    parameter int N_TRAPS = 8,
    localparam int IDX_W = (N_TRAPS > 1) ? $clog2(N_TRAPS) : 1
) (
    input  logic [N_TRAPS-1:0]   pend,
    input  logic [2*N_TRAPS-1:0] cls,
    input  logic                 cur_abortable,
    input  logic                 iter_bound,
    input  logic                 instr_end,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx
);
    import trap_seq_pkg::*;

    logic [N_TRAPS-1:0] elig;

    for (genvar g = 0; g < N_TRAPS; g++) begin : g_elig
        logic boundary_met;
        always_comb begin
            case (cls[2*g +: 2])
                CLS_ABORT: boundary_met = cur_abortable;
                CLS_ITER:  boundary_met = iter_bound;
                default:   boundary_met = instr_end;
            endcase
        end
        assign elig[g] = pend[g] & boundary_met;
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N_TRAPS - 1; i >= 0; i--) begin
            if (elig[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/trap_loc_check.sv
module trap_loc_check #(
    parameter int OPC_W = 7,
    parameter logic [OPC_W-1:0] OPC_XCHG = 7'h0F,
    parameter logic [OPC_W-1:0] OPC_PUSH = 7'h0B
) (
    input  logic [OPC_W-1:0] opcode,
    output logic             legal
);
    assign legal = (opcode == OPC_XCHG) || (opcode == OPC_PUSH);
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
    parameter int N_TRAPS = 8,
    parameter int ADDR_W  = 10,
    parameter logic [ADDR_W-1:0] TRAP_BASE = 10'h040,
    parameter int EXC_NUM = 6,
    parameter int OPC_W   = 7,
    parameter logic [OPC_W-1:0] OPC_XCHG = 7'h0F,
    parameter logic [OPC_W-1:0] OPC_PUSH = 7'h0B
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_TRAPS-1:0]   trap_req,
    input  logic [2*N_TRAPS-1:0] trap_class,
    input  logic                 cur_abortable,
    input  logic                 iter_bound,
    input  logic                 instr_end,
    input  logic [OPC_W-1:0]     loc_opcode,
    input  logic                 loc_opcode_vld,
    input  logic                 intr_ready,
    input  logic                 swap_done,
    output logic [ADDR_W-1:0]    trap_addr,
    output logic                 pc_hold,
    output logic                 trap_state,
    output logic                 intr_ack_gate,
    output logic                 swap_start
);
    import trap_seq_pkg::*;

    localparam int IDX_W = (N_TRAPS > 1) ? $clog2(N_TRAPS) : 1;
    localparam logic [IDX_W-1:0] EXC_IDX = IDX_W'(EXC_NUM);

    typedef struct packed {
        seq_state_e         st;
        logic [N_TRAPS-1:0] pend;
        logic [IDX_W-1:0]   num;
        logic               go;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             pick_hit;
    logic [IDX_W-1:0] pick_idx;
    logic             opc_legal;

    trap_pick #(.N_TRAPS(N_TRAPS)) u_pick (
        .pend          (r_q.pend),
        .cls           (trap_class),
        .cur_abortable (cur_abortable),
        .iter_bound    (iter_bound),
        .instr_end     (instr_end),
        .hit           (pick_hit),
        .idx           (pick_idx)
    );

    trap_loc_check #(
        .OPC_W    (OPC_W),
        .OPC_XCHG (OPC_XCHG),
        .OPC_PUSH (OPC_PUSH)
    ) u_loc (
        .opcode (loc_opcode),
        .legal  (opc_legal)
    );

    always_comb begin
        r_d    = r_q;
        r_d.go = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (pick_hit) begin
                    r_d.st             = ST_FETCH;
                    r_d.num            = pick_idx;
                    r_d.pend[pick_idx] = 1'b0;
                end
            end
            ST_FETCH: begin
                if (loc_opcode_vld) begin
                    if (opc_legal) begin
                        r_d.st = ST_SWAP;
                        r_d.go = 1'b1;
                    end else begin
                        r_d.num = EXC_IDX;
                    end
                end
            end
            ST_SWAP: begin
                if (swap_done) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        r_d.pend = r_d.pend | trap_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, pend: '0, num: '0, go: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign trap_state    = (r_q.st != ST_IDLE);
    assign pc_hold       = trap_state;
    assign swap_start    = r_q.go;
    assign intr_ack_gate = intr_ready & ~trap_state;
    assign trap_addr     = TRAP_BASE + {{(ADDR_W-IDX_W){1'b0}}, r_q.num};
endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
    parameter int N_TRAPS = 8,
    parameter int ADDR_W  = 10,
    parameter logic [ADDR_W-1:0] TRAP_BASE = 10'h040
) (
    input logic              clk,
    input logic              rst_n,
    input logic              intr_ready,
    input logic              trap_state,
    input logic              pc_hold,
    input logic              swap_start,
    input logic              intr_ack_gate,
    input logic [ADDR_W-1:0] trap_addr
);
    localparam logic [ADDR_W:0] ADDR_END = {1'b0, TRAP_BASE} + (ADDR_W+1)'(N_TRAPS);

    // R7
    swap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_start |=> !swap_start);

    // R7
    swap_in_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_start |-> trap_state);

    // R5
    idle_no_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_state |=> !swap_start);

    // R5
    hold_in_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_state |-> pc_hold);

    // R9
    ack_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_state |-> !intr_ack_gate);

    // R9
    ack_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_state && intr_ready) |-> intr_ack_gate);

    // R6
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_state |-> (trap_addr >= TRAP_BASE && {1'b0, trap_addr} < ADDR_END));
endmodule

bind trap_entry_seq trap_entry_seq_chk #(
    .N_TRAPS   (N_TRAPS),
    .ADDR_W    (ADDR_W),
    .TRAP_BASE (TRAP_BASE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .intr_ready    (intr_ready),
    .trap_state    (trap_state),
    .pc_hold       (pc_hold),
    .swap_start    (swap_start),
    .intr_ack_gate (intr_ack_gate),
    .trap_addr     (trap_addr)
);

// File: tb/trap_entry_seq_bench.sv
module trap_entry_seq_bench;
    localparam int N = 8;
    localparam int AW = 10;
    localparam int BASE = 'h040;
    localparam int EXC = 6;
    localparam int OW = 7;
    localparam logic [OW-1:0] XCHG = 7'h0F;
    localparam logic [OW-1:0] PUSH = 7'h0B;
    localparam logic [OW-1:0] BAD  = 7'h22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]   trap_req = '0;
    logic [2*N-1:0] trap_class = '0;
    logic cur_abortable = 1'b0, iter_bound = 1'b0, instr_end = 1'b0;
    logic [OW-1:0] loc_opcode = '0;
    logic loc_opcode_vld = 1'b0, intr_ready = 1'b0, swap_done = 1'b0;
    logic [AW-1:0] trap_addr;
    logic pc_hold, trap_state, intr_ack_gate, swap_start;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    trap_entry_seq u_trap_entry_seq (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_class(trap_class),
        .cur_abortable(cur_abortable), .iter_bound(iter_bound), .instr_end(instr_end),
        .loc_opcode(loc_opcode), .loc_opcode_vld(loc_opcode_vld),
        .intr_ready(intr_ready), .swap_done(swap_done),
        .trap_addr(trap_addr), .pc_hold(pc_hold), .trap_state(trap_state),
        .intr_ack_gate(intr_ack_gate), .swap_start(swap_start)
    );

    // reference model: 0 idle, 1 opcode wait, 2 swap
    int          m_st = 0;
    logic [N-1:0] m_pend = '0;
    int          m_num = 0;
    logic        m_go = 1'b0;

    function automatic int pick_ref(logic [N-1:0] p, logic [2*N-1:0] c,
                                    logic ab, logic it, logic ie);
        for (int i = 0; i < N; i++) begin
            logic ok;
            case (c[2*i +: 2])
                2'd0: ok = ab;
                2'd1: ok = it;
                default: ok = ie;
            endcase
            if (p[i] && ok) return i;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pend = '0; m_num = 0; m_go = 1'b0;
        end else begin
            m_go = 1'b0;
            if (m_st == 0) begin
                int k;
                k = pick_ref(m_pend, trap_class, cur_abortable, iter_bound, instr_end);
                if (k >= 0) begin
                    m_st = 1; m_num = k; m_pend[k] = 1'b0;
                end
            end else if (m_st == 1) begin
                if (loc_opcode_vld) begin
                    if (loc_opcode == XCHG || loc_opcode == PUSH) begin
                        m_st = 2; m_go = 1'b1;
                    end else begin
                        m_num = EXC;
                    end
                end
            end else if (swap_done) begin
                m_st = 0;
            end
            m_pend = m_pend | trap_req;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        chk(trap_state == (m_st != 0), "R5 trap_state", trap_state, m_st != 0);
        chk(pc_hold == (m_st != 0), "R5 pc_hold", pc_hold, m_st != 0);
        chk(swap_start == m_go, "R7 swap_start", swap_start, m_go);
        chk(intr_ack_gate == (intr_ready && m_st == 0), "R9 intr_ack_gate",
            intr_ack_gate, intr_ready && m_st == 0);
        if (m_st != 0)
            chk(trap_addr == AW'(BASE + m_num), "R6 trap_addr", trap_addr, BASE + m_num);
    endtask

    // one clock; outputs compared at the falling edge, then pulse inputs cleared
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_model();
        trap_req = '0; iter_bound = 0; instr_end = 0; cur_abortable = 0;
        loc_opcode_vld = 0; swap_done = 0;
    endtask

    task automatic set_cls(input int i, input logic [1:0] c);
        trap_class[2*i +: 2] = c;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        intr_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(trap_state == 0 && pc_hold == 0 && swap_start == 0, "R1 reset outputs",
            {trap_state, pc_hold, swap_start}, 0);
        chk(intr_ack_gate == 1, "R1 ack gate follows ready", intr_ack_gate, 1);

        // R3 abort class waits for cur_abortable
        set_cls(5, 2'd0);
        trap_req[5] = 1; step();
        iter_bound = 1; instr_end = 1; step();
        chk(trap_state == 0, "R3 abort class not taken on other strobes", trap_state, 0);
        cur_abortable = 1; step();
        chk(trap_state == 1 && pc_hold == 1, "R5 trap entered", {trap_state, pc_hold}, 3);
        chk(trap_addr == AW'(BASE + 5), "R6 address of trap 5", trap_addr, BASE + 5);
        chk(intr_ack_gate == 0, "R9 ack held off", intr_ack_gate, 0);

        // R8 illegal opcode nests to exception trap, R7 legal starts swap
        loc_opcode = BAD; loc_opcode_vld = 1; step();
        chk(trap_addr == AW'(BASE + EXC) && swap_start == 0, "R8 nested exception trap",
            trap_addr, BASE + EXC);
        loc_opcode = XCHG; loc_opcode_vld = 1; step();
        chk(swap_start == 1, "R7 swap start pulse", swap_start, 1);
        step();
        chk(swap_start == 0 && trap_state == 1, "R7 pulse one cycle", swap_start, 0);
        swap_done = 1; step();
        chk(trap_state == 0 && intr_ack_gate == 1, "R10 sequence ends", trap_state, 0);

        // R4 lowest first, R2 other stays pending
        set_cls(3, 2'd2); set_cls(1, 2'd3);
        trap_req[3] = 1; trap_req[1] = 1; step();
        instr_end = 1; step();
        chk(trap_addr == AW'(BASE + 1), "R4 lowest number taken", trap_addr, BASE + 1);
        loc_opcode = PUSH; loc_opcode_vld = 1; step();
        swap_done = 1; step();
        instr_end = 1; step();
        chk(trap_state == 1 && trap_addr == AW'(BASE + 3), "R2 remaining request taken",
            trap_addr, BASE + 3);
        loc_opcode = XCHG; loc_opcode_vld = 1; step();
        swap_done = 1; step();

        // R11 opcode outside wait phase, R10 done outside swap phase
        loc_opcode = XCHG; loc_opcode_vld = 1; swap_done = 1; step();
        chk(swap_start == 0 && trap_state == 0, "R11 stray opcode ignored", swap_start, 0);

        // R3 iteration class
        set_cls(2, 2'd1);
        trap_req[2] = 1; step();
        instr_end = 1; cur_abortable = 1; step();
        chk(trap_state == 0, "R3 iteration class waits", trap_state, 0);
        iter_bound = 1; step();
        chk(trap_addr == AW'(BASE + 2) && trap_state == 1, "R3 iteration class taken",
            trap_addr, BASE + 2);
        loc_opcode = PUSH; loc_opcode_vld = 1; step();
        swap_done = 1; step();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            trap_class = 2*N'($urandom);
            trap_req = (($urandom % 4) == 0) ? N'(1 << ($urandom % N)) : '0;
            cur_abortable = ($urandom % 5) == 0;
            iter_bound = ($urandom % 5) == 0;
            instr_end = ($urandom % 4) == 0;
            loc_opcode_vld = ($urandom % 3) == 0;
            case ($urandom % 4)
                0: loc_opcode = BAD;
                1: loc_opcode = PUSH;
                default: loc_opcode = XCHG;
            endcase
            swap_done = ($urandom % 3) == 0;
            intr_ready = $urandom % 2;
            step();
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule